// File: doc/BRIEF.md
# Exception Entry and Status Control

This block keeps the 32-bit status word of a simple in-order processor core and decides, every cycle, whether the core must enter an exception handler. It watches four pending requests: external interrupt, decrementer, machine check and illegal operation. It also watches what the core reports about the instruction that retires: whether it is valid, whether it is a branch, whether it already raised an exception, whether it is privileged, and whether it is a floating-point instruction. Gate bits in the status word qualify each candidate cause. A fixed priority then picks one cause.

On entry the block makes a one-cycle take pulse and a handler vector address. It saves the return address and the old status word. It clears the enable bits that a handler must start without, and it loads the live byte-order bit from the exception byte-order bit. A return-from-exception input restores the saved status word and at once presents the saved address as the redirect target. Software writes to the status word keep reserved bits at zero.

Status bits use big-endian numbering: status bit n is stored at vector index 31-n of `status`.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, `status`, `save_status`, `save_pc` and `take_exc` are all zero.
- R2: A write (`st_wr`) stores `st_wdata` with the reserved status bits 0-12, 14 and 24 forced to zero. This gives writable mask 0x0005_FF7F in vector order, so writing all ones reads back as 0x0005_FF7F.
- R3: The external and decrementer requests are taken only while status bit 16 (vector bit 15, interrupt enable) is 1. While that bit is 0, a held request stays pending and is taken once the bit becomes 1.
- R4: A machine-check request is taken only while status bit 19 (vector bit 12) is 1. Otherwise it raises nothing.
- R5: A program exception is raised by `req_illegal`, or by a valid privileged retire while status bit 17 (vector bit 14, user mode) is 1. A floating-point-unavailable exception is raised by a valid floating-point retire while status bit 18 (vector bit 13) is 0.
- R6: A trace exception is raised on a valid retire that has no other exception in the following cases: status bit 21 (vector bit 10) is 1, or status bit 22 (vector bit 9) is 1 and the retire is a branch.
- R7: When several causes are present together, the priority is machine check, then program, then floating-point unavailable, then trace, then external, then decrementer.
- R8: `vec_addr` is a base plus an offset. The base is 0x0000_0000, or 0xFFF0_0000 when status bit 25 (vector bit 6) is 1. The offsets are: machine check 0x200, external 0x500, program 0x700, floating-point unavailable 0x800, decrementer 0x900, trace 0xD00.
- R9: A cause present at a clock edge gives `take_exc` = 1 for the next cycle only, together with the vector. At that edge several registers update. `save_status` gets the old status. `save_pc` gets `fault_pc` for program and floating-point-unavailable causes, and `resume_pc` for all other causes. Status bits 16, 17, 18, 21, 22, 26 and 27 are cleared, and status bit 31 (vector bit 0) is loaded from status bit 15 (vector bit 16).
- R10: While `rfi` is high, `redirect` is 1 and `redirect_pc` equals `save_pc` in the same cycle. At the edge, `status` is loaded from `save_status` through the writable mask.
- R11: Exception entry wins over `rfi` and over a write in the same cycle. `rfi` wins over a write.
- R12: `le_mode`, `user_mode`, `itrans_en` and `dtrans_en` show status bits 31, 17, 26 and 27 (vector bits 0, 14, 5 and 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ext | input | 1 | External interrupt pending |
| req_dec | input | 1 | Decrementer event pending |
| req_mchk | input | 1 | Machine-check request |
| req_illegal | input | 1 | Illegal-operation request |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_branch | input | 1 | Retiring instruction is a branch |
| rt_exc | input | 1 | Retiring instruction already raised an exception |
| rt_priv | input | 1 | Retiring instruction is privileged |
| rt_fp | input | 1 | Retiring instruction is floating-point |
| fault_pc | input | 32 | Address of the retiring instruction |
| resume_pc | input | 32 | Address to resume at after the current point |
| rfi | input | 1 | Return from exception |
| st_wr | input | 1 | Software write to the status word |
| st_wdata | input | 32 | Status write data |
| take_exc | output | 1 | Exception entry pulse |
| vec_addr | output | 32 | Handler vector address |
| redirect | output | 1 | Redirect request on return |
| redirect_pc | output | 32 | Return target address |
| status | output | 32 | Live status word |
| save_pc | output | 32 | Saved return address |
| save_status | output | 32 | Saved status word |
| le_mode | output | 1 | Little-endian byte order active |
| user_mode | output | 1 | User privilege level active |
| itrans_en | output | 1 | Instruction translation enabled |
| dtrans_en | output | 1 | Data translation enabled |

## Verification
A vector table pairs status words with request and retire patterns.
- Each cause appears with its gate bit both open and closed, which shows that the gate, not the request alone, makes the decision.
- Mixed patterns, such as machine check with external, a privileged fault with external, and trace with both interrupts, separate the priority levels.
- A floating-point fault under single-step shows that trace yields to a real fault.
- Vector offsets are also tried against the high base.

Directed tests then cover several sequences:
- A held interrupt that is enabled late.
- The reserved-bit mask.
- The round trip of the byte-order and privilege bits through entry and return.
- Entry, return and write colliding in the same cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN   = 32;
  localparam int NCAUSE = 6;

  // vector indices of status bits (status bit n lives at XLEN-1-n)
  localparam int B_POW = XLEN - 1 - 13;
  localparam int B_ILE = XLEN - 1 - 15;
  localparam int B_EE  = XLEN - 1 - 16;
  localparam int B_PR  = XLEN - 1 - 17;
  localparam int B_FP  = XLEN - 1 - 18;
  localparam int B_ME  = XLEN - 1 - 19;
  localparam int B_SE  = XLEN - 1 - 21;
  localparam int B_BE  = XLEN - 1 - 22;
  localparam int B_IP  = XLEN - 1 - 25;
  localparam int B_IR  = XLEN - 1 - 26;
  localparam int B_DR  = XLEN - 1 - 27;
  localparam int B_LE  = XLEN - 1 - 31;

  typedef enum logic [2:0] {
    C_NONE, C_MCHK, C_PROG, C_FPU, C_TRACE, C_EXT, C_DEC
  } cause_e;

  function automatic logic [XLEN-1:0] mk_wr_mask();
    logic [XLEN-1:0] m;
    m = '1;
    for (int n = 0; n <= 12; n++) m[XLEN-1-n] = 1'b0;
    m[XLEN-1-14] = 1'b0;
    m[XLEN-1-24] = 1'b0;
    return m;
  endfunction

  localparam logic [XLEN-1:0] WR_MASK = mk_wr_mask();

  function automatic logic [XLEN-1:0] mk_entry_clr();
    logic [XLEN-1:0] m;
    m = '0;
    m[B_EE] = 1'b1; m[B_PR] = 1'b1; m[B_FP] = 1'b1;
    m[B_SE] = 1'b1; m[B_BE] = 1'b1; m[B_IR] = 1'b1; m[B_DR] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] ENTRY_CLR = mk_entry_clr();

  // priority slot (0 = highest) to cause
  function automatic cause_e slot_cause(int slot);
    case (slot)
      0:       return C_MCHK;
      1:       return C_PROG;
      2:       return C_FPU;
      3:       return C_TRACE;
      4:       return C_EXT;
      5:       return C_DEC;
      default: return C_NONE;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vec_off(cause_e c);
    case (c)
      C_MCHK:  return XLEN'(12'h200);
      C_EXT:   return XLEN'(12'h500);
      C_PROG:  return XLEN'(12'h700);
      C_FPU:   return XLEN'(12'h800);
      C_DEC:   return XLEN'(12'h900);
      C_TRACE: return XLEN'(12'hD00);
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vec_base(logic hi);
    return hi ? 32'hFFF0_0000 : 32'h0000_0000;
  endfunction

  function automatic logic [XLEN-1:0] entry_status(logic [XLEN-1:0] old);
    logic [XLEN-1:0] s;
    s = old & ~ENTRY_CLR;
    s[B_LE] = old[B_ILE];
    return s;
  endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic              en_int,
  input  logic              en_mchk,
  input  logic              user_lvl,
  input  logic              fp_ok,
  input  logic              step_en,
  input  logic              br_en,
  input  logic              req_ext,
  input  logic              req_dec,
  input  logic              req_mchk,
  input  logic              req_illegal,
  input  logic              rt_valid,
  input  logic              rt_branch,
  input  logic              rt_exc,
  input  logic              rt_priv,
  input  logic              rt_fp,
  output logic [NCAUSE-1:0] grant,
  output logic              hit,
  output cause_e            cause,
  output logic              use_fault
);
  logic ev_prog, ev_fpu, ev_trace;
  logic [NCAUSE-1:0] ev;

  assign ev_prog  = req_illegal | (rt_valid & rt_priv & user_lvl);
  assign ev_fpu   = rt_valid & rt_fp & ~fp_ok;
  assign ev_trace = rt_valid & ~rt_exc & ~ev_prog & ~ev_fpu
                  & (step_en | (br_en & rt_branch));

  // slot order is priority order
  assign ev = {req_dec & en_int, req_ext & en_int, ev_trace,
               ev_fpu, ev_prog, req_mchk & en_mchk};

  always_comb begin
    grant = '0;
    cause = C_NONE;
    for (int i = 0; i < NCAUSE; i++) begin
      if (ev[i] && grant == '0) begin
        grant[i] = 1'b1;
        cause    = slot_cause(i);
      end
    end
  end

  assign hit       = |grant;
  assign use_fault = (cause == C_PROG) || (cause == C_FPU);
endmodule

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  cause_e          cause,
  input  logic            use_fault,
  input  logic [XLEN-1:0] fault_pc,
  input  logic [XLEN-1:0] resume_pc,
  input  logic            rfi,
  input  logic            st_wr,
  input  logic [XLEN-1:0] st_wdata,
  output logic [XLEN-1:0] stat,
  output logic [XLEN-1:0] save_pc,
  output logic [XLEN-1:0] save_stat,
  output logic            take_q,
  output logic [XLEN-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat      <= '0;
      save_pc   <= '0;
      save_stat <= '0;
      take_q    <= 1'b0;
      vec_q     <= '0;
    end else if (hit) begin
      save_pc   <= use_fault ? fault_pc : resume_pc;
      save_stat <= stat;
      stat      <= entry_status(stat);
      take_q    <= 1'b1;
      vec_q     <= vec_base(stat[B_IP]) | vec_off(cause);
    end else begin
      take_q <= 1'b0;
      if (rfi)        stat <= save_stat & WR_MASK;
      else if (st_wr) stat <= st_wdata & WR_MASK;
    end
  end

  // R9
  entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> save_stat == $past(stat));

  // R9
  entry_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> stat[B_LE] == save_stat[B_ILE]);

  // R10
  rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rfi && !hit) |=> stat == ($past(save_stat) & WR_MASK));

  // R2
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !rfi && !hit) |=> stat == ($past(st_wdata) & WR_MASK));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_ext,
  input  logic        req_dec,
  input  logic        req_mchk,
  input  logic        req_illegal,
  input  logic        rt_valid,
  input  logic        rt_branch,
  input  logic        rt_exc,
  input  logic        rt_priv,
  input  logic        rt_fp,
  input  logic [31:0] fault_pc,
  input  logic [31:0] resume_pc,
  input  logic        rfi,
  input  logic        st_wr,
  input  logic [31:0] st_wdata,
  output logic        take_exc,
  output logic [31:0] vec_addr,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic [31:0] status,
  output logic [31:0] save_pc,
  output logic [31:0] save_status,
  output logic        le_mode,
  output logic        user_mode,
  output logic        itrans_en,
  output logic        dtrans_en
);
  logic [NCAUSE-1:0] grant;
  logic              hit;
  cause_e            cause;
  logic              use_fault;

  trap_arbiter u_arb (
    .en_int     (status[B_EE]),
    .en_mchk    (status[B_ME]),
    .user_lvl   (status[B_PR]),
    .fp_ok      (status[B_FP]),
    .step_en    (status[B_SE]),
    .br_en      (status[B_BE]),
    .req_ext    (req_ext),
    .req_dec    (req_dec),
    .req_mchk   (req_mchk),
    .req_illegal(req_illegal),
    .rt_valid   (rt_valid),
    .rt_branch  (rt_branch),
    .rt_exc     (rt_exc),
    .rt_priv    (rt_priv),
    .rt_fp      (rt_fp),
    .grant      (grant),
    .hit        (hit),
    .cause      (cause),
    .use_fault  (use_fault)
  );

  trap_status u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .cause    (cause),
    .use_fault(use_fault),
    .fault_pc (fault_pc),
    .resume_pc(resume_pc),
    .rfi      (rfi),
    .st_wr    (st_wr),
    .st_wdata (st_wdata),
    .stat     (status),
    .save_pc  (save_pc),
    .save_stat(save_status),
    .take_q   (take_exc),
    .vec_q    (vec_addr)
  );

  assign redirect    = rfi;
  assign redirect_pc = save_pc;
  assign le_mode     = status[B_LE];
  assign user_mode   = status[B_PR];
  assign itrans_en   = status[B_IR];
  assign dtrans_en   = status[B_DR];

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && vec_addr[19:0] == 20'h00500) |-> $past(status[B_EE]));

  // R4
  mchk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && vec_addr[19:0] == 20'h00200) |-> $past(status[B_ME]));

  // R8
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> vec_addr[31:20] == ($past(status[B_IP]) ? 12'hFFF : 12'h000));
endmodule

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_ext = 0, req_dec = 0, req_mchk = 0, req_illegal = 0;
  logic rt_valid = 0, rt_branch = 0, rt_exc = 0, rt_priv = 0, rt_fp = 0;
  logic [31:0] fault_pc = 0, resume_pc = 0, st_wdata = 0;
  logic rfi = 0, st_wr = 0;
  logic take_exc, redirect, le_mode, user_mode, itrans_en, dtrans_en;
  logic [31:0] vec_addr, redirect_pc, status, save_pc, save_status;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trap_ctrl dut_i (.*);

  localparam logic [31:0] M_WR = 32'h0005_FF7F;
  localparam logic [31:0] M_CLR = 32'h0000_E630;

  // {status, {mchk,illegal,ext,dec}, {valid,branch,exc,priv,fp}, take, vector}
  localparam int NV = 17;
  localparam logic [73:0] VT [0:NV-1] = '{
    {32'h0000_0000, 4'b0010, 5'b00000, 1'b0, 32'h0000_0000},
    {32'h0000_8000, 4'b0010, 5'b00000, 1'b1, 32'h0000_0500},
    {32'h0000_8040, 4'b0001, 5'b00000, 1'b1, 32'hFFF0_0900},
    {32'h0000_0000, 4'b1000, 5'b00000, 1'b0, 32'h0000_0000},
    {32'h0000_9000, 4'b1010, 5'b00000, 1'b1, 32'h0000_0200},
    {32'h0000_C000, 4'b0010, 5'b10010, 1'b1, 32'h0000_0700},
    {32'h0000_0000, 4'b0000, 5'b10001, 1'b1, 32'h0000_0800},
    {32'h0000_2000, 4'b0000, 5'b10001, 1'b0, 32'h0000_0000},
    {32'h0000_0400, 4'b0000, 5'b10000, 1'b1, 32'h0000_0D00},
    {32'h0000_0400, 4'b0000, 5'b10100, 1'b0, 32'h0000_0000},
    {32'h0000_0200, 4'b0000, 5'b11000, 1'b1, 32'h0000_0D00},
    {32'h0000_0200, 4'b0000, 5'b10000, 1'b0, 32'h0000_0000},
    {32'h0000_8400, 4'b0011, 5'b10000, 1'b1, 32'h0000_0D00},
    {32'h0000_8000, 4'b0011, 5'b00000, 1'b1, 32'h0000_0500},
    {32'h0001_8070, 4'b0010, 5'b00000, 1'b1, 32'hFFF0_0500},
    {32'h0000_0000, 4'b0100, 5'b00000, 1'b1, 32'h0000_0700},
    {32'h0000_0400, 4'b0000, 5'b10001, 1'b1, 32'h0000_0800}
  };

  function automatic logic [31:0] model_entry(logic [31:0] s);
    return (s & ~M_CLR & ~32'h1) | ((s >> 16) & 32'h1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_status(input logic [31:0] v);
    st_wr = 1; st_wdata = v;
    cyc();
    st_wr = 0;
  endtask

  task automatic clear_in();
    {req_mchk, req_illegal, req_ext, req_dec} = '0;
    {rt_valid, rt_branch, rt_exc, rt_priv, rt_fp} = '0;
    rfi = 0; st_wr = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] ex;
    repeat (3) cyc();
    rst_n = 1;
    // R1 reset state
    chk(status == 0, "R1 status", status, 0);
    chk(save_status == 0 && save_pc == 0, "R1 save", save_pc, 0);
    chk(take_exc == 0, "R1 take", {31'b0, take_exc}, 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [31:0] s0, vx;
      logic [3:0] rq;
      logic [4:0] rt;
      logic tk;
      {s0, rq, rt, tk, vx} = VT[i];
      wr_status(s0);
      {req_mchk, req_illegal, req_ext, req_dec} = rq;
      {rt_valid, rt_branch, rt_exc, rt_priv, rt_fp} = rt;
      fault_pc = 32'h1000 + 32'(i) * 8;
      resume_pc = fault_pc + 4;
      cyc();
      chk(take_exc == tk, $sformatf("R3-7 take vec%0d", i), {31'b0, take_exc}, {31'b0, tk});
      if (tk) begin
        chk(vec_addr == vx, $sformatf("R8 vector vec%0d", i), vec_addr, vx);
        chk(save_status == s0, $sformatf("R9 saved status vec%0d", i), save_status, s0);
        ex = (vx[11:0] == 12'h700 || vx[11:0] == 12'h800) ? fault_pc : resume_pc;
        chk(save_pc == ex, $sformatf("R9 saved pc vec%0d", i), save_pc, ex);
        chk(status == model_entry(s0), $sformatf("R9 entry status vec%0d", i),
            status, model_entry(s0));
      end else begin
        chk(status == s0, $sformatf("R3 status unchanged vec%0d", i), status, s0);
      end
      clear_in();
      cyc();
      chk(take_exc == 0, $sformatf("R9 single pulse vec%0d", i), {31'b0, take_exc}, 0);
    end

    // R3: held interrupt taken once enabled, not retaken after entry clears enable
    wr_status(32'h0);
    req_ext = 1;
    cyc();
    chk(take_exc == 0, "R3 held pending", {31'b0, take_exc}, 0);
    wr_status(32'h0000_8000);
    chk(take_exc == 0, "R3 write cycle", {31'b0, take_exc}, 0);
    cyc();
    chk(take_exc == 1 && vec_addr == 32'h500, "R3 late take", vec_addr, 32'h500);
    cyc();
    chk(take_exc == 0, "R3 no retake", {31'b0, take_exc}, 0);
    clear_in();

    // R2 / R12: reserved mask and control outputs
    wr_status(32'hFFFF_FFFF);
    chk(status == M_WR, "R2 mask", status, M_WR);
    chk(le_mode && user_mode && itrans_en && dtrans_en, "R12 controls on",
        {28'b0, le_mode, user_mode, itrans_en, dtrans_en}, 32'hF);

    // R9 R10 R12: byte order and privilege round trip
    wr_status(32'h0001_C000);
    req_ext = 1; resume_pc = 32'h0000_4444;
    cyc();
    req_ext = 0;
    chk(status == 32'h0001_0001, "R9 entry LE copy", status, 32'h0001_0001);
    chk(le_mode == 1 && user_mode == 0, "R12 handler controls",
        {30'b0, le_mode, user_mode}, 32'h2);
    rfi = 1;
    #1;
    chk(redirect == 1 && redirect_pc == 32'h0000_4444, "R10 redirect", redirect_pc,
        32'h0000_4444);
    cyc();
    rfi = 0;
    chk(status == 32'h0001_C000, "R10 restore", status, 32'h0001_C000);
    chk(user_mode == 1 && le_mode == 0, "R12 restored controls",
        {30'b0, le_mode, user_mode}, 32'h1);

    // R11: entry beats rfi and write
    wr_status(32'h0000_8000);
    req_ext = 1; rfi = 1; st_wr = 1; st_wdata = 32'h0000_2000;
    cyc();
    clear_in();
    chk(take_exc == 1, "R11 entry wins take", {31'b0, take_exc}, 1);
    chk(status == 32'h0 && save_status == 32'h0000_8000, "R11 entry wins status",
        status, 32'h0);
    // R11: rfi beats write
    rfi = 1; st_wr = 1; st_wdata = 32'h0000_2000;
    cyc();
    clear_in();
    chk(status == 32'h0000_8000, "R11 rfi over write", status, 32'h0000_8000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule